// File: doc/BRIEF.md
# Serial Configuration Word Loader

This block sits on the device side of a three-wire programming port. A host selects it with an active-low select line, toggles a serial clock, and presents data on a single data pin. A load session opens only when the select line rises while the data pin is high and the serial clock is low. The block then takes exactly sixteen bits, one on each rising serial clock edge, into a shadow shift register.

The block commits the word to the decoded configuration outputs in one step, and only after the sixteenth bit. It then raises a loaded flag. From that point on, and until the next reset, any further port activity has no effect. Before a word has been committed, the outputs hold the unprogrammed defaults, which are all zero. All three port pins are asynchronous to the system clock. The block synchronizes them and detects their edges in the system clock domain.

Top module: `cfg_shift_loader`

## Requirements
- R1: After reset, and until a word is committed, `loaded` is 0 and all decoded fields read 0: `dir_ccw`=0, `zero_pos`=0, `idx_wide`=0, `div_sel`=00 and `out_mode`=00.
- R2: A load session opens only on a rising edge of `sel_n` while `pdata` is high and `sclk` is low. If `sel_n` rises with `pdata` low, or with `sclk` high, a later run of sixteen serial clock pulses leaves `loaded` at 0 and every field at 0.
- R3: During a session, one data bit is taken from `pdata` on each rising edge of `sclk`. Falling edges of `sclk` take no bit.
- R4: The word's bits map to fields in arrival order. Bit 1 goes to `dir_ccw`. Bits 2 to 11 go to `zero_pos`, most significant bit first. Bit 12 goes to `idx_wide`. Bits 13 and 14 go to `div_sel[1]` and `div_sel[0]`. Bits 15 and 16 go to `out_mode[1]` and `out_mode[0]`.
- R5: `loaded` rises after the sixteenth captured bit and not after the fifteenth. It does so within four system clocks of the sixteenth rising edge of `sclk`.
- R6: The fields never show a partial word. After fifteen bits they still read their defaults, and all of them change together when `loaded` rises.
- R7: Once `loaded` is 1, further `sclk` pulses, `pdata` changes and `sel_n` edges change neither the fields nor `loaded`.
- R8: An open session, and the loaded state, end only through reset. A reset in the middle of a session discards the partial word, and a later session loads a full new word correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Asynchronous port select; its rising edge may open a session |
| sclk | input | 1 | Asynchronous serial clock; rising edge takes a bit |
| pdata | input | 1 | Asynchronous serial data, also the session-entry qualifier |
| dir_ccw | output | 1 | Decoded direction bit |
| zero_pos | output | ZERO_W | Decoded zero position |
| idx_wide | output | 1 | Decoded index-width select |
| div_sel | output | 2 | Decoded divider select |
| out_mode | output | 2 | Decoded output mode |
| loaded | output | 1 | A full word has been committed |

## Verification
The bench loads walking-one, walking-zero and mixed words, one per reset. Each load exercises every field bit. A design that reverses the arrival order, or that maps a bit to the wrong field, fails here. After the fifteenth bit the bench checks that `loaded` is still low and that the fields still hold their defaults. A design that counts off by one, or that drives the fields straight from the shift register, shows a torn word at that point. The bench also opens sessions with the data pin low and with the serial clock high. A design that arms on any select edge would load a word in those sessions. Finally, the bench sends more pulses and select edges after a load, and resets in the middle of a load. A design that re-arms, keeps shifting after the load, or keeps the partial word across reset is caught by these steps.

// File: rtl/cfg_shift_loader.sv
module cfg_shift_loader #(
  parameter int SYNC_STAGES = 2,
  parameter int ZERO_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              pdata,
  output logic              dir_ccw,
  output logic [ZERO_W-1:0] zero_pos,
  output logic              idx_wide,
  output logic [1:0]        div_sel,
  output logic [1:0]        out_mode,
  output logic              loaded
);
  localparam int WORD_BITS = ZERO_W + 6;
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BITS - 1);

  logic [SYNC_STAGES:0] sel_sr, sclk_sr, dat_sr;
  logic                 armed;
  logic [CNT_W-1:0]     cnt;
  logic [WORD_BITS-2:0] shreg;
  logic [WORD_BITS-1:0] cfg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_sr  <= '1;
      sclk_sr <= '0;
      dat_sr  <= '0;
    end else begin
      sel_sr  <= {sel_sr[SYNC_STAGES-1:0], sel_n};
      sclk_sr <= {sclk_sr[SYNC_STAGES-1:0], sclk};
      dat_sr  <= {dat_sr[SYNC_STAGES-1:0], pdata};
    end

  wire sel_rise  = sel_sr[SYNC_STAGES-1] & ~sel_sr[SYNC_STAGES];
  wire sclk_rise = sclk_sr[SYNC_STAGES-1] & ~sclk_sr[SYNC_STAGES];
  wire sclk_lvl  = sclk_sr[SYNC_STAGES-1];
  wire dat_bit   = dat_sr[SYNC_STAGES-1];
  wire take      = armed & ~loaded & sclk_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b0;
      loaded <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      cfg    <= '0;
    end else begin
      if (!armed && sel_rise && dat_bit && !sclk_lvl)
        armed <= 1'b1;
      if (take) begin
        shreg <= {shreg[WORD_BITS-3:0], dat_bit};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          cfg    <= {shreg, dat_bit};
          loaded <= 1'b1;
        end
      end
    end

  assign dir_ccw  = cfg[WORD_BITS-1];
  assign zero_pos = cfg[WORD_BITS-2 -: ZERO_W];
  assign idx_wide = cfg[4];
  assign div_sel  = cfg[3:2];
  assign out_mode = cfg[1:0];

  p_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> (cfg == '0));
  p_load_needs_session_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> $past(armed));
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_BITS));
  p_whole_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $rose(loaded));
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> (loaded && $stable(cfg)));
  p_session_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: tb/cfg_shift_loader_test.sv
module cfg_shift_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;

  logic clk = 1'b0, rst_n = 1'b0, sel_n = 1'b0, sclk = 1'b0, pdata = 1'b0;
  logic dir_ccw, idx_wide, loaded;
  logic [9:0] zero_pos;
  logic [1:0] div_sel, out_mode;
  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] seen;

  cfg_shift_loader uut (.clk, .rst_n, .sel_n, .sclk, .pdata, .dir_ccw,
    .zero_pos, .idx_wide, .div_sel, .out_mode, .loaded);

  always #(CLK_PERIOD/2) clk = ~clk;

  assign seen = {dir_ccw, zero_pos, idx_wide, div_sel, out_mode};

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_n = 1'b0; sclk = 1'b0; pdata = 1'b0;
    waitn(STEP);
    rst_n = 1'b1;
    waitn(STEP);
  endtask

  task automatic open_session(logic dat, logic ck);
    sel_n = 1'b0; pdata = dat; sclk = ck; waitn(STEP);
    sel_n = 1'b1; waitn(STEP);
    sclk = 1'b0; waitn(STEP);
  endtask

  task automatic send_bit(logic b);
    pdata = b; waitn(STEP);
    sclk = 1'b1; waitn(STEP);
    sclk = 1'b0; waitn(STEP);
  endtask

  task automatic load_word(logic [15:0] w);
    open_session(1'b1, 1'b0);
    for (int i = 15; i >= 1; i--) send_bit(w[i]);
    check("R6 partial word hidden", {loaded, seen}, 17'h0);
    send_bit(w[0]);
    check("R4 R5 field mapping", {loaded, seen}, {1'b1, w});
    check("R4 zero position", {7'h0, zero_pos}, {7'h0, w[14:5]});
  endtask

  initial begin
    do_reset();
    check("R1 reset defaults", {loaded, seen}, 17'h0);

    for (int k = 0; k < 16; k++) begin
      do_reset();
      load_word(16'h1 << k);
      do_reset();
      load_word(~(16'h1 << k));
    end
    do_reset();
    load_word(16'hA5C3);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    sel_n = 1'b0; waitn(STEP); sel_n = 1'b1; waitn(STEP);
    for (int i = 0; i < 16; i++) send_bit(i[0]);
    check("R7 frozen after load", {loaded, seen}, {1'b1, 16'hA5C3});

    do_reset();
    open_session(1'b0, 1'b0);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    check("R2 no entry with data low", {loaded, seen}, 17'h0);

    do_reset();
    open_session(1'b1, 1'b1);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    check("R2 no entry with sclk high", {loaded, seen}, 17'h0);

    do_reset();
    open_session(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin
      pdata = 1'b1; waitn(STEP);
      sclk = 1'b1; waitn(STEP);
      pdata = 1'b0; waitn(STEP);
      sclk = 1'b0; waitn(STEP);
    end
    check("R3 rising edge sampling", {loaded, seen}, {1'b1, 16'hFFFF});

    do_reset();
    open_session(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    do_reset();
    check("R8 reset drops partial", {loaded, seen}, 17'h0);
    for (int i = 0; i < 16; i++) send_bit(1'b1);
    check("R8 session closed by reset", {loaded, seen}, 17'h0);
    load_word(16'h3C96);
    check("R8 reload after reset", {loaded, seen}, {1'b1, 16'h3C96});

    do_reset();
    open_session(1'b1, 1'b0);
    for (int i = 0; i < 15; i++) send_bit(1'b1);
    pdata = 1'b1; waitn(STEP);
    sclk = 1'b1;
    waitn(STEP);
    check("R5 loaded within four clocks", {16'h0, loaded}, 17'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule